// File: doc/BRIEF.md
# Command Ring Word Fetcher

This block supplies a command processor with a stream of 32-bit command words. The words come from one of two kinds of buffer. The first is a circular primary ring in memory, which the host fills. The host programs the ring's byte base and a size code, then publishes a write pointer whenever it has appended work. The fetcher reads words through a synchronous memory port and passes them to a consumer over a valid/ready handshake. The consumer reports, after each packet, how many words it used; only then does the read pointer of the active buffer move. The host can read back the primary read pointer at any time.

The consumer can also redirect fetching to an indirect buffer. It does this by giving a byte address and a length in words. Indirect buffers are complete when they are entered. They are read linearly, they end exactly at their length, and they ignore the host write pointer. Jumps nest through a small stack of saved buffer contexts. When an indirect buffer runs out, the fetcher returns to the buffer that called it and continues from that buffer's saved read pointer. A jump that would exceed the stack depth is dropped and raises a sticky error flag.

Top module: `cmd_ring_fetch`

## Requirements
- R1: A size code c sets the primary ring to 1 << (c + 1) words (1 << (c + 3) bytes). Codes above MAX_CODE are treated as MAX_CODE. The word at read offset i on the primary ring is fetched from byte address base + 4 × ((rptr + i) mod size).
- R2: An init pulse selects circular mode, sets the read and write pointers to 0, empties the stack, discards any word not yet delivered, and clears the overflow flag. Afterwards busy is 0 and no word is offered.
- R3: A host write-pointer write stores the value reduced modulo the primary size. It always lands in the primary ring, even when an indirect buffer is active and the primary ring is saved on the stack. It never changes an indirect buffer's length.
- R4: The primary ring has words pending whenever rptr ≠ wptr, including when wptr has wrapped below rptr. Those words are delivered in ring order and wrap from the last slot to slot 0.
- R5: An advance of n words moves the active read pointer by n, modulo the size on the primary ring. Words that were delivered but not yet advanced over are not fetched again.
- R6: A jump to (addr, len) enters an indirect buffer with rptr 0 and a fixed end at len. Its words come from addr + 4 × i for i = 0 … len − 1, with no modulo wrap even past the primary size. A word prefetched from the calling buffer is discarded.
- R7: Once an indirect buffer's rptr reaches its length, it is popped. The saved caller resumes at its saved read pointer.
- R8: host_rptr always shows the primary ring's read pointer and never an indirect buffer's.
- R9: busy is 1 when the active buffer or any saved buffer on the stack has words pending.
- R10: With STACK_DEPTH contexts saved, a further jump is ignored and fetching continues unchanged. That jump sets overflow_err, which stays set until reset or init.
- R11: cmd_data holds steady while cmd_valid is 1 and cmd_ready is 0. At most one memory read is outstanding; read data is taken in the cycle after mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_init | input | 1 | Pulse: (re)initialise the primary ring |
| cfg_base | input | ADDR_W | Primary ring byte base, taken on cfg_init |
| cfg_size_code | input | CODE_W | Ring size code, taken on cfg_init |
| wptr_we | input | 1 | Host write-pointer write strobe |
| wptr_data | input | PTR_W | Host write-pointer value in words |
| host_rptr | output | PTR_W | Primary read pointer mirror |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_req |
| cmd_valid | output | 1 | Command word offered |
| cmd_data | output | DATA_W | Command word |
| cmd_ready | input | 1 | Consumer accepts the word |
| adv_valid | input | 1 | Consumer reports packet consumption |
| adv_count | input | PTR_W | Words consumed by the packet |
| jump_req | input | 1 | Enter an indirect buffer |
| jump_addr | input | ADDR_W | Indirect buffer byte address |
| jump_len | input | PTR_W | Indirect buffer length in words |
| busy | output | 1 | Any active or saved buffer has pending words |
| overflow_err | output | 1 | Sticky: a jump was dropped on a full stack |

## Verification
The in-line properties check several things on every cycle. The primary pointers stay inside the programmed ring. An indirect buffer's read pointer never moves backwards and its end never moves. host_rptr stays frozen while any indirect buffer is active. The overflow flag is sticky, the stack pointer never exceeds its depth, an init leaves the block idle, and a stalled word is held while only one read is in flight. Some behaviour only the bench scenarios can show. These are the exact fetch addresses across a ring wrap and past the ring size inside an indirect buffer. They also include the modulo reduction of host write pointers, the resume point after a pop, the dropped jump on a full stack, and busy staying set from a saved ring when the active buffer is exhausted.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;

   typedef enum logic {
      MODE_CIRC   = 1'b0,
      MODE_LINEAR = 1'b1
   } buf_mode_e;

   // Offset of a word from the buffer base, in words.
   function automatic logic [31:0] ring_offset(input logic [31:0] rptr,
                                               input logic [31:0] ofs,
                                               input logic [31:0] mask,
                                               input buf_mode_e   mode);
      logic [31:0] sum;
      sum = rptr + ofs;
      return (mode == MODE_LINEAR) ? sum : (sum & mask);
   endfunction

   // Words waiting between read and write pointers.
   function automatic logic [31:0] pend_words(input logic [31:0] rptr,
                                              input logic [31:0] wptr,
                                              input logic [31:0] mask,
                                              input buf_mode_e   mode);
      if (mode == MODE_LINEAR) return (wptr > rptr) ? (wptr - rptr) : 32'd0;
      return (wptr - rptr) & mask;
   endfunction

   function automatic logic has_pending(input logic [31:0] rptr,
                                        input logic [31:0] wptr,
                                        input buf_mode_e   mode);
      if (mode == MODE_LINEAR) return rptr < wptr;
      return rptr != wptr;
   endfunction

endpackage

// File: rtl/cmdf_ctx_stack.sv
module cmdf_ctx_stack
   import cmdf_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 16,
   localparam int SP_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_base,
   input  logic [PTR_W-1:0]  push_rptr,
   input  logic [PTR_W-1:0]  push_wptr,
   input  buf_mode_e         push_mode,
   input  logic              pop,
   input  logic              bot_we,
   input  logic [PTR_W-1:0]  bot_wptr,
   output logic [SP_W-1:0]   sp,
   output logic [ADDR_W-1:0] top_base,
   output logic [PTR_W-1:0]  top_rptr,
   output logic [PTR_W-1:0]  top_wptr,
   output buf_mode_e         top_mode,
   output logic [PTR_W-1:0]  bot_rptr,
   output logic              saved_busy
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("cmdf_ctx_stack: DEPTH must be at least 1");
   end

   logic [ADDR_W-1:0] s_base [DEPTH];
   logic [PTR_W-1:0]  s_rptr [DEPTH];
   logic [PTR_W-1:0]  s_wptr [DEPTH];
   buf_mode_e         s_mode [DEPTH];
   logic [DEPTH-1:0]  ent_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            s_base[i] <= '0;
            s_rptr[i] <= '0;
            s_wptr[i] <= '0;
            s_mode[i] <= MODE_CIRC;
         end
      end else if (clear) begin
         sp <= '0;
      end else begin
         // host pointer lands in the bottom (primary) slot
         if (bot_we) s_wptr[0] <= bot_wptr;
         if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (sp == SP_W'(i)) begin
                  s_base[i] <= push_base;
                  s_rptr[i] <= push_rptr;
                  s_wptr[i] <= push_wptr;
                  s_mode[i] <= push_mode;
               end
            end
            sp <= sp + SP_W'(1);
         end else if (pop) begin
            sp <= sp - SP_W'(1);
         end
      end
   end

   always_comb begin
      top_base = s_base[0];
      top_rptr = s_rptr[0];
      top_wptr = s_wptr[0];
      top_mode = s_mode[0];
      for (int i = 1; i < DEPTH; i++) begin
         if (sp == SP_W'(i + 1)) begin
            top_base = s_base[i];
            top_rptr = s_rptr[i];
            top_wptr = s_wptr[i];
            top_mode = s_mode[i];
         end
      end
   end

   assign bot_rptr = s_rptr[0];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      assign ent_pend[gi] = (sp > SP_W'(gi)) &&
                            has_pending(32'(s_rptr[gi]), 32'(s_wptr[gi]), s_mode[gi]);
   end
   assign saved_busy = |ent_pend;

   p_sp_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sp) <= DEPTH);

   p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> 32'(sp) < DEPTH);

   p_push_pop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

endmodule

// File: rtl/cmdf_word_port.sv
module cmdf_word_port #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              issue,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              cmd_ready,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_data,
   output logic              inflight,
   output logic              capture
);

   assign capture = inflight && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight  <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_data  <= '0;
      end else begin
         inflight <= issue;
         if (flush) begin
            cmd_valid <= 1'b0;
         end else if (capture) begin
            cmd_valid <= 1'b1;
            cmd_data  <= mem_rdata;
         end else if (cmd_valid && cmd_ready) begin
            cmd_valid <= 1'b0;
         end
      end
   end

   p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue);

   p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready && !flush |=> cmd_valid && $stable(cmd_data));

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import cmdf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CODE_W      = 4,
   parameter int MAX_CODE    = 14,
   parameter int STACK_DEPTH = 4,
   parameter bit CLAMP_CODE  = 1'b1,
   localparam int PTR_W      = MAX_CODE + 2,
   localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_init,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CODE_W-1:0] cfg_size_code,
   input  logic              wptr_we,
   input  logic [PTR_W-1:0]  wptr_data,
   output logic [PTR_W-1:0]  host_rptr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_ready,
   input  logic              adv_valid,
   input  logic [PTR_W-1:0]  adv_count,
   input  logic              jump_req,
   input  logic [ADDR_W-1:0] jump_addr,
   input  logic [PTR_W-1:0]  jump_len,
   output logic              busy,
   output logic              overflow_err
);

   if (PTR_W > 31) begin : g_bad_ptr
      $error("cmd_ring_fetch: MAX_CODE too large for 32-bit pointer math");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("cmd_ring_fetch: CODE_W cannot express MAX_CODE");
   end
   if (ADDR_W > 32 || ADDR_W < PTR_W + 2) begin : g_bad_addr
      $error("cmd_ring_fetch: ADDR_W out of range");
   end
   if (STACK_DEPTH < 1) begin : g_bad_stack
      $error("cmd_ring_fetch: STACK_DEPTH must be at least 1");
   end

   // ---------------- active context ----------------
   logic              inited;
   logic [ADDR_W-1:0] a_base;
   logic [PTR_W-1:0]  a_rptr, a_wptr, mask_q, fofs;
   buf_mode_e         a_mode;
   logic              ovf;

   // ---------------- size code decode ----------------
   logic [CODE_W-1:0] code_eff;
   logic [PTR_W-1:0]  mask_new;

   if (CLAMP_CODE) begin : g_clamp
      always_comb code_eff = (32'(cfg_size_code) > MAX_CODE) ? CODE_W'(MAX_CODE)
                                                               : cfg_size_code;
   end else begin : g_raw
      assign code_eff = cfg_size_code;
   end

   always_comb begin
      for (int b = 0; b < PTR_W; b++) mask_new[b] = (b <= int'(code_eff));
   end

   // ---------------- stack ----------------
   logic [SP_W-1:0]   sp;
   logic [ADDR_W-1:0] top_base;
   logic [PTR_W-1:0]  top_rptr, top_wptr, bot_rptr;
   buf_mode_e         top_mode;
   logic              saved_busy;

   // ---------------- control ----------------
   logic              jump_acc, jump_rej, pop_go, flush, act_pend;
   logic [PTR_W-1:0]  wptr_red, wptr_cur, rptr_adv, pop_wptr, avail, fofs_nxt;
   logic              issue, inflight, capture;
   logic [31:0]       fetch_off;

   assign wptr_red = wptr_data & mask_q;
   assign act_pend = inited && has_pending(32'(a_rptr), 32'(a_wptr), a_mode);
   assign jump_acc = jump_req && inited && !cfg_init && (32'(sp) < STACK_DEPTH);
   assign jump_rej = jump_req && inited && !cfg_init && (32'(sp) >= STACK_DEPTH);
   assign pop_go   = inited && !cfg_init && !jump_acc && (a_mode == MODE_LINEAR) &&
                     !act_pend && (sp != '0);
   assign flush    = cfg_init || jump_acc || pop_go;

   assign rptr_adv = adv_valid ?
                     PTR_W'(ring_offset(32'(a_rptr), 32'(adv_count), 32'(mask_q), a_mode))
                     : a_rptr;
   assign wptr_cur = (wptr_we && inited && sp == '0) ? wptr_red : a_wptr;
   assign pop_wptr = (wptr_we && sp == SP_W'(1)) ? wptr_red : top_wptr;
   assign fofs_nxt = fofs + PTR_W'(capture) - (adv_valid ? adv_count : '0);

   assign avail     = PTR_W'(pend_words(32'(a_rptr), 32'(a_wptr), 32'(mask_q), a_mode));
   assign issue     = inited && !flush && !inflight && !cmd_valid && (fofs < avail);
   assign fetch_off = ring_offset(32'(a_rptr), 32'(fofs), 32'(mask_q), a_mode);
   assign mem_req   = issue;
   assign mem_addr  = a_base + (ADDR_W'(fetch_off) << 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inited <= 1'b0;
         a_base <= '0;
         a_rptr <= '0;
         a_wptr <= '0;
         a_mode <= MODE_CIRC;
         mask_q <= '0;
         fofs   <= '0;
         ovf    <= 1'b0;
      end else if (cfg_init) begin
         inited <= 1'b1;
         a_base <= cfg_base;
         a_rptr <= '0;
         a_wptr <= '0;
         a_mode <= MODE_CIRC;
         mask_q <= mask_new;
         fofs   <= '0;
         ovf    <= 1'b0;
      end else begin
         if (jump_rej) ovf <= 1'b1;
         if (jump_acc) begin
            a_base <= jump_addr;
            a_rptr <= '0;
            a_wptr <= jump_len;
            a_mode <= MODE_LINEAR;
            fofs   <= '0;
         end else if (pop_go) begin
            a_base <= top_base;
            a_rptr <= top_rptr;
            a_wptr <= pop_wptr;
            a_mode <= top_mode;
            fofs   <= '0;
         end else begin
            a_rptr <= rptr_adv;
            a_wptr <= wptr_cur;
            fofs   <= fofs_nxt;
         end
      end
   end

   cmdf_ctx_stack #(
      .DEPTH (STACK_DEPTH),
      .ADDR_W(ADDR_W),
      .PTR_W (PTR_W)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cfg_init),
      .push      (jump_acc),
      .push_base (a_base),
      .push_rptr (rptr_adv),
      .push_wptr (wptr_cur),
      .push_mode (a_mode),
      .pop       (pop_go),
      .bot_we    (wptr_we && inited && sp != '0),
      .bot_wptr  (wptr_red),
      .sp        (sp),
      .top_base  (top_base),
      .top_rptr  (top_rptr),
      .top_wptr  (top_wptr),
      .top_mode  (top_mode),
      .bot_rptr  (bot_rptr),
      .saved_busy(saved_busy)
   );

   cmdf_word_port #(
      .DATA_W(DATA_W)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .issue    (issue),
      .mem_rdata(mem_rdata),
      .cmd_ready(cmd_ready),
      .cmd_valid(cmd_valid),
      .cmd_data (cmd_data),
      .inflight (inflight),
      .capture  (capture)
   );

   assign host_rptr    = (sp == '0) ? a_rptr : bot_rptr;
   assign busy         = act_pend || saved_busy;
   assign overflow_err = ovf;

   p_circ_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      inited && a_mode == MODE_CIRC |-> ((a_rptr & ~mask_q) == '0) && ((a_wptr & ~mask_q) == '0));

   p_init_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_init |=> !busy && !cmd_valid && !overflow_err);

   p_ib_end_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      a_mode == MODE_LINEAR && !flush |=> $stable(a_wptr));

   p_ib_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
      a_mode == MODE_LINEAR && !flush |=> a_rptr >= $past(a_rptr));

   p_mirror_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inited && sp != '0 && !cfg_init |=> $stable(host_rptr));

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_err && !cfg_init |=> overflow_err);

endmodule

// File: tb/cmd_ring_fetch_bench.sv
module cmd_ring_fetch_bench;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int CODE_W = 4;
   localparam int PTR_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_init;
   logic [ADDR_W-1:0] cfg_base;
   logic [CODE_W-1:0] cfg_size_code;
   logic              wptr_we;
   logic [PTR_W-1:0]  wptr_data;
   logic [PTR_W-1:0]  host_rptr;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic              cmd_valid;
   logic [DATA_W-1:0] cmd_data;
   logic              cmd_ready;
   logic              adv_valid;
   logic [PTR_W-1:0]  adv_count;
   logic              jump_req;
   logic [ADDR_W-1:0] jump_addr;
   logic [PTR_W-1:0]  jump_len;
   logic              busy;
   logic              overflow_err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cmd_ring_fetch u_cmd_ring_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_init     (cfg_init),
      .cfg_base     (cfg_base),
      .cfg_size_code(cfg_size_code),
      .wptr_we      (wptr_we),
      .wptr_data    (wptr_data),
      .host_rptr    (host_rptr),
      .mem_req      (mem_req),
      .mem_addr     (mem_addr),
      .mem_rdata    (mem_rdata),
      .cmd_valid    (cmd_valid),
      .cmd_data     (cmd_data),
      .cmd_ready    (cmd_ready),
      .adv_valid    (adv_valid),
      .adv_count    (adv_count),
      .jump_req     (jump_req),
      .jump_addr    (jump_addr),
      .jump_len     (jump_len),
      .busy         (busy),
      .overflow_err (overflow_err)
   );

   // Memory content is a function of the byte address.
   function automatic logic [31:0] mem_fn(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, a[31:16] ^ a[15:0] ^ 16'h0F0F};
   endfunction

   always @(posedge clk) if (mem_req) mem_rdata <= mem_fn(mem_addr);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic take_word(output logic [31:0] d);
      int t;
      t = 0;
      @(negedge clk);
      cmd_ready = 1'b1;
      while (!cmd_valid && t < 200) begin
         @(negedge clk);
         t++;
      end
      d = cmd_valid ? cmd_data : 32'hDEAD_BEEF;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic expect_word(input string req, input logic [31:0] addr);
      logic [31:0] d;
      take_word(d);
      check(req, d, mem_fn(addr));
   endtask

   task automatic advance(input int n);
      @(negedge clk);
      adv_valid = 1'b1;
      adv_count = PTR_W'(n);
      @(negedge clk);
      adv_valid = 1'b0;
   endtask

   task automatic jump(input logic [31:0] a, input int n);
      @(negedge clk);
      jump_req  = 1'b1;
      jump_addr = a;
      jump_len  = PTR_W'(n);
      @(negedge clk);
      jump_req = 1'b0;
   endtask

   task automatic host_wp(input int v);
      @(negedge clk);
      wptr_we   = 1'b1;
      wptr_data = PTR_W'(v);
      @(negedge clk);
      wptr_we = 1'b0;
   endtask

   task automatic ring_init(input logic [31:0] b, input int code);
      @(negedge clk);
      cfg_init      = 1'b1;
      cfg_base      = b;
      cfg_size_code = CODE_W'(code);
      @(negedge clk);
      cfg_init = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
   end

   initial begin
      logic [31:0] held;
      int unsigned seed_init;
      seed_init = $urandom(32'd1357);
      rst_n = 1'b0;
      cfg_init = 1'b0; cfg_base = '0; cfg_size_code = '0;
      wptr_we = 1'b0; wptr_data = '0; cmd_ready = 1'b0;
      adv_valid = 1'b0; adv_count = '0;
      jump_req = 1'b0; jump_addr = '0; jump_len = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset busy", 32'(busy), 0);
      check("R2 reset cmd_valid", 32'(cmd_valid), 0);
      check("R10 reset overflow", 32'(overflow_err), 0);
      check("R8 reset host_rptr", 32'(host_rptr), 0);

      // ring of 8 words (code 2)
      ring_init(32'h0000_1000, 2);
      repeat (4) @(negedge clk);
      check("R2 init busy", 32'(busy), 0);
      check("R2 init no word", 32'(cmd_valid), 0);

      host_wp(5);
      check("R4 pending after wptr", 32'(busy), 1);
      for (int i = 0; i < 5; i++) expect_word("R1 ring word", 32'h1000 + 4 * i);
      advance(5);
      check("R5 rptr after advance", 32'(host_rptr), 5);
      check("R4 empty", 32'(busy), 0);

      // write 11 -> reduced to 3, wptr now below rptr
      host_wp(11);
      for (int i = 0; i < 6; i++)
         expect_word("R3 R4 wrapped word", 32'h1000 + 4 * ((5 + i) % 8));
      advance(6);
      check("R5 rptr wraps", 32'(host_rptr), 3);
      check("R3 reduced wptr leaves ring empty", 32'(busy), 0);

      // indirect buffer while primary has pending words
      host_wp(5);
      expect_word("R1 word before jump", 32'h100C);
      advance(1);
      jump(32'h0000_8000, 3);
      expect_word("R6 ib word0", 32'h8000);
      expect_word("R6 ib word1", 32'h8004);
      check("R8 mirror keeps primary", 32'(host_rptr), 4);
      host_wp(7);
      check("R8 mirror after host write", 32'(host_rptr), 4);
      expect_word("R6 ib word2", 32'h8008);
      advance(3);
      check("R9 busy from saved ring", 32'(busy), 1);
      expect_word("R7 R3 resume primary", 32'h1010);
      expect_word("R7 primary next", 32'h1014);
      expect_word("R3 host wptr reached primary", 32'h1018);
      advance(3);
      check("R5 rptr after resume", 32'(host_rptr), 7);
      check("R9 all empty", 32'(busy), 0);

      // indirect buffer longer than ring: linear addresses
      jump(32'h0000_9000, 10);
      check("R9 busy from ib", 32'(busy), 1);
      for (int i = 0; i < 10; i++) expect_word("R6 linear past size", 32'h9000 + 4 * i);
      advance(10);
      check("R9 exhausted ib, empty ring", 32'(busy), 0);
      check("R8 mirror unchanged", 32'(host_rptr), 7);

      // nesting to full depth, then an ignored jump
      host_wp(8);
      expect_word("R4 last slot", 32'h101C);
      advance(1);
      for (int l = 0; l < 4; l++) begin
         jump(32'h0000_A000 + 32'(l) * 32'h100, 4);
         expect_word("R6 nested word0", 32'hA000 + l * 32'h100);
         advance(1);
      end
      check("R10 no overflow yet", 32'(overflow_err), 0);
      jump(32'h0000_F000, 4);
      check("R10 overflow set", 32'(overflow_err), 1);
      expect_word("R10 jump ignored", 32'hA304);
      advance(1);
      for (int l = 3; l >= 0; l--) begin
         int st;
         st = (l == 3) ? 2 : 1;
         for (int i = st; i < 4; i++) expect_word("R7 unwind", 32'hA000 + l * 32'h100 + 4 * i);
         advance(4 - st);
      end
      check("R7 back on primary", 32'(host_rptr), 0);
      check("R9 idle after unwind", 32'(busy), 0);
      check("R10 overflow sticky", 32'(overflow_err), 1);

      // init clears state; stalled word is held
      ring_init(32'h0000_2000, 1);
      check("R2 init clears overflow", 32'(overflow_err), 0);
      host_wp(2);
      repeat (6) @(negedge clk);
      check("R11 word offered", 32'(cmd_valid), 1);
      held = cmd_data;
      repeat (3) @(negedge clk);
      check("R11 word held", cmd_data, held);
      check("R11 held value", held, mem_fn(32'h2000));
      expect_word("R11 held word taken", 32'h2000);
      expect_word("R1 second word", 32'h2004);
      advance(2);

      // size code above the limit is clamped: 15 -> 14 -> 32768 words
      ring_init(32'h0010_0000, 15);
      host_wp(32'h8000 + 3);
      for (int i = 0; i < 3; i++) expect_word("R1 clamped code", 32'h0010_0000 + 4 * i);
      advance(3);
      check("R1 clamped size reduces wptr", 32'(busy), 0);

      // random rings
      for (int r = 0; r < 4; r++) begin
         int code, size, rp, wp;
         logic [31:0] base;
         code = int'($urandom % 4);
         size = 2 << code;
         base = $urandom & 32'h00FF_F000;
         ring_init(base, code);
         rp = 0;
         wp = 0;
         for (int k = 0; k < 10; k++) begin
            int n, rem;
            n = 1 + int'($urandom % (size - 1));
            wp = (wp + n) % size;
            host_wp(wp + size * int'($urandom % 4));
            for (int i = 0; i < n; i++)
               expect_word("R1 R4 random word", base + 4 * ((rp + i) % size));
            rem = n;
            while (rem > 0) begin
               int c;
               c = 1 + int'($urandom % rem);
               advance(c);
               rp = (rp + c) % size;
               rem -= c;
               check("R5 R3 random rptr", 32'(host_rptr), rp);
            end
            check("R4 random drained", 32'(busy), 0);
         end
      end

      report();
      $finish;
   end

endmodule